// File: doc/BRIEF.md
# Asynchronous Serial Port with Clear-to-Send Gating

This block is a full-duplex asynchronous serial port that sits on a small parallel register bus. Software writes a character into a one-entry transmit buffer. The transmitter sends it only while the active-low clear-to-send input is asserted. The receiver watches its serial input for a start bit, rebuilds the character, checks it, and places it in a one-entry receive buffer for software to read.

Each bit is 16 ticks of a programmable divider. The frame has a start bit, then 7 or 8 data bits sent LSB first, then a parity bit whose sense can be set, then one or two stop bits. Receive problems are latched into a three-bit sticky error register. Three level interrupts report the port's state: receive data waiting, transmit buffer free, and any error latched.

Top module: `uart_cts_port`

## Requirements
- R1: After reset, txd_o is 1, rx_irq_o is 0, tx_irq_o is 1 and err_irq_o is 0. Reading address 1 (mode) gives 0x01, address 2 (divisor) gives 0x00 and address 3 (errors) gives 0x00.
- R2: A transmitted frame has these bits in order:
  - a 0 start bit;
  - the data bits LSB first, 8 of them when mode bit 0 is 1 and 7 when it is 0;
  - one parity bit that makes the count of ones over the data bits plus parity even (mode bit 1 = 0) or odd (mode bit 1 = 1);
  - one stop bit of 1, or two when mode bit 2 is 1.

  Every bit lasts 16*(divisor+1) clock cycles.
- R3: A frame starts only while cts_ni is low. A buffered character waits, with txd_o held at 1, for as long as cts_ni stays high.
- R4: tx_irq_o is 1 while the transmit buffer is empty. A write to address 0 fills the buffer and clears tx_irq_o. tx_irq_o returns to 1 when the transmitter takes the character.
- R5: Reception starts on a falling edge of rxd_i. The start bit is checked at its middle, so a low pulse shorter than half a bit is ignored and no character is received.
- R6: A received character sets rx_irq_o. Reading address 0 returns the character and clears rx_irq_o. In 7-bit mode, bit 7 of the read data is 0.
- R7: A received parity bit that does not match the selected sense sets error bit 2.
- R8: A stop bit sampled as 0 sets error bit 1. In two-stop mode this applies to either stop bit.
- R9: A character that completes while the receive buffer is still unread sets error bit 0. That new character is discarded and the buffered one is kept.
- R10: Error bits stay set until a write to address 3 with a 1 in that bit position. Writing a 0 leaves the bit unchanged. err_irq_o is 1 while any error bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 data, 1 mode, 2 divisor, 3 errors |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; a read of address 0 consumes the receive buffer |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| cts_ni | input | 1 | Clear to send, active low |
| rx_irq_o | output | 1 | Received character waiting |
| tx_irq_o | output | 1 | Transmit buffer empty |
| err_irq_o | output | 1 | At least one error bit set |

## Verification
Most internal faults show up within a single frame time.
- A miscounted bit index or tick counter in the transmitter shifts or drops bits. This is visible at txd_o on the next frame.
- A stuck transmit state leaves txd_o low, or leaves tx_irq_o low past the frame.
- A receiver fault shows at the next read of address 0 or address 3, one frame after the stimulus, as wrong data or a wrong error bit.
- Broken error latching shows on err_irq_o the cycle after the frame completes.
- A broken clear-to-send gate shows as a start bit while cts_ni is high.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef struct packed {
    logic two_stop;
    logic odd_par;
    logic len8;
  } mode_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam logic [1:0] ADDR_ERR  = 2'd3;

  localparam int ERR_OVR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_PAR = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } line_st_e;

  function automatic logic par_bit(input logic [7:0] d, input mode_t m);
    logic [7:0] v;
    v = m.len8 ? d : {1'b0, d[6:0]};
    return (^v) ^ m.odd_par;
  endfunction
endpackage

// File: rtl/uart_sync.sv
module uart_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps a shrinking divisor from wrapping the full range
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  mode_t      mode_i,
  input  logic       start_ok_i,
  input  logic [7:0] data_i,
  output logic       load_o,
  output logic       busy_o,
  output logic       txd_o
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] TCK_LAST = CW'(OVS - 1);

  line_st_e       st_q;
  logic [7:0]     sh_q;
  logic           par_q;
  logic [2:0]     bit_q;
  logic [CW-1:0]  tck_q;
  logic           stop2_q;
  logic           bit_end;
  logic [2:0]     last_bit;

  assign load_o   = (st_q == ST_IDLE) && start_ok_i;
  assign busy_o   = (st_q != ST_IDLE);
  assign bit_end  = tick_i && (tck_q == TCK_LAST);
  assign last_bit = mode_i.len8 ? 3'd7 : 3'd6;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sh_q    <= '0;
      par_q   <= 1'b0;
      bit_q   <= '0;
      tck_q   <= '0;
      stop2_q <= 1'b0;
    end else if (st_q == ST_IDLE) begin
      if (start_ok_i) begin
        st_q    <= ST_START;
        sh_q    <= data_i;
        par_q   <= par_bit(data_i, mode_i);
        tck_q   <= '0;
        bit_q   <= '0;
        stop2_q <= 1'b0;
      end
    end else if (tick_i) begin
      tck_q <= bit_end ? '0 : tck_q + 1'b1;
      if (bit_end) begin
        unique case (st_q)
          ST_START: st_q <= ST_DATA;
          ST_DATA: begin
            sh_q  <= {1'b0, sh_q[7:1]};
            bit_q <= bit_q + 1'b1;
            if (bit_q == last_bit) st_q <= ST_PAR;
          end
          ST_PAR: st_q <= ST_STOP;
          ST_STOP: begin
            if (mode_i.two_stop && !stop2_q) stop2_q <= 1'b1;
            else                             st_q    <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  mode_t      mode_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       perr_o,
  output logic       ferr_o
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] TCK_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] TCK_MID  = CW'(OVS / 2 - 1);

  line_st_e      st_q;
  logic          prev_q;
  logic [CW-1:0] tck_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          par_bad_q;
  logic          frm_bad_q;
  logic          stop2_q;
  logic [7:0]    dat;
  logic          smp;
  logic          stop_bad;

  assign dat      = mode_i.len8 ? sh_q : {1'b0, sh_q[7:1]};
  assign smp      = tick_i && (tck_q == TCK_LAST);
  assign stop_bad = frm_bad_q | ~rxd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      prev_q    <= 1'b1;
      tck_q     <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      par_bad_q <= 1'b0;
      frm_bad_q <= 1'b0;
      stop2_q   <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      perr_o    <= 1'b0;
      ferr_o    <= 1'b0;
    end else begin
      prev_q <= rxd_i;
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (prev_q && !rxd_i) begin
            st_q  <= ST_START;
            tck_q <= '0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (tck_q == TCK_MID) begin
              tck_q <= '0;
              bit_q <= '0;
              st_q  <= rxd_i ? ST_IDLE : ST_DATA;
            end else begin
              tck_q <= tck_q + 1'b1;
            end
          end
        end
        default: begin
          if (tick_i) tck_q <= smp ? '0 : tck_q + 1'b1;
          if (smp) begin
            if (st_q == ST_DATA) begin
              sh_q  <= {rxd_i, sh_q[7:1]};
              bit_q <= bit_q + 1'b1;
              if (bit_q == (mode_i.len8 ? 3'd7 : 3'd6)) st_q <= ST_PAR;
            end else if (st_q == ST_PAR) begin
              par_bad_q <= (rxd_i != par_bit(dat, mode_i));
              frm_bad_q <= 1'b0;
              stop2_q   <= 1'b0;
              st_q      <= ST_STOP;
            end else if (mode_i.two_stop && !stop2_q) begin
              frm_bad_q <= stop_bad;
              stop2_q   <= 1'b1;
            end else begin
              done_o <= 1'b1;
              data_o <= dat;
              perr_o <= par_bad_q;
              ferr_o <= stop_bad;
              st_q   <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_cts_port.sv
module uart_cts_port
  import uart_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rxd_i,
  output logic       txd_o,
  input  logic       cts_ni,
  output logic       rx_irq_o,
  output logic       tx_irq_o,
  output logic       err_irq_o
);
  localparam int ERR_W = 3;

  logic             tick;
  logic             rxd_s;
  logic             cts_s;
  mode_t            mode_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       tb_q;
  logic             tb_full;
  logic [7:0]       rb_q;
  logic             rb_full;
  logic [ERR_W-1:0] err_q;
  logic [ERR_W-1:0] err_set;
  logic [ERR_W-1:0] err_clr;
  logic             tx_load;
  logic             tx_busy;
  logic             rx_done;
  logic [7:0]       rx_data;
  logic             rx_perr;
  logic             rx_ferr;
  logic             wr_data;
  logic             rd_data;
  logic             ovr;

  uart_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rxd (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s)
  );

  uart_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cts (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cts_ni), .q_o(cts_s)
  );

  uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_q), .tick_o(tick)
  );

  uart_tx #(.OVS(OVS)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .mode_i(mode_q),
    .start_ok_i(tb_full && !cts_s), .data_i(tb_q),
    .load_o(tx_load), .busy_o(tx_busy), .txd_o(txd_o)
  );

  uart_rx #(.OVS(OVS)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd_s),
    .mode_i(mode_q), .done_o(rx_done), .data_o(rx_data),
    .perr_o(rx_perr), .ferr_o(rx_ferr)
  );

  assign wr_data = wr_en_i && (addr_i == ADDR_DATA);
  assign rd_data = rd_en_i && (addr_i == ADDR_DATA);
  assign ovr     = rx_done && rb_full && !rd_data;

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = ovr;
    err_set[ERR_FRM] = rx_done && rx_ferr;
    err_set[ERR_PAR] = rx_done && rx_perr;
    err_clr          = (wr_en_i && addr_i == ADDR_ERR) ? wdata_i[ERR_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '{two_stop: 1'b0, odd_par: 1'b0, len8: 1'b1};
      div_q   <= '0;
      tb_q    <= '0;
      tb_full <= 1'b0;
      rb_q    <= '0;
      rb_full <= 1'b0;
      err_q   <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_MODE) mode_q <= mode_t'(wdata_i[2:0]);
      if (wr_en_i && addr_i == ADDR_DIV)  div_q  <= wdata_i[DIV_W-1:0];

      // a write in the load cycle refills the buffer
      if (wr_data) begin
        tb_q    <= wdata_i;
        tb_full <= 1'b1;
      end else if (tx_load) begin
        tb_full <= 1'b0;
      end

      if (rx_done && !ovr) begin
        rb_q    <= rx_data;
        rb_full <= 1'b1;
      end else if (rd_data) begin
        rb_full <= 1'b0;
      end

      err_q <= (err_q & ~err_clr) | err_set;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rdata_o = rb_q;
      ADDR_MODE: rdata_o = {5'b0, mode_q};
      ADDR_DIV:  rdata_o = 8'(div_q);
      default:   rdata_o = {{(8-ERR_W){1'b0}}, err_q};
    endcase
  end

  assign rx_irq_o  = rb_full;
  assign tx_irq_o  = !tb_full;
  assign err_irq_o = |err_q;
endmodule

// File: rtl/uart_cts_port_chk.sv
module uart_cts_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [2:0] clr_bits,
  input logic       cts_s,
  input logic       tx_busy,
  input logic       tx_load,
  input logic       tb_full,
  input logic       rx_done,
  input logic       rb_full,
  input logic [2:0] err_q,
  input logic       rx_irq_o
);
  logic [2:0] keep;
  logic       rd_data;

  assign keep    = err_q & ~((wr_en_i && addr_i == 2'd3) ? clr_bits : 3'b0);
  assign rd_data = rd_en_i && addr_i == 2'd0;

  a_r3_no_start_when_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load |-> !cts_s);

  a_r3_idle_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_busy && cts_s) |=> !tx_busy);

  a_r4_load_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load |-> tb_full);

  a_r6_rx_irq_follows_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && !rb_full) |=> rx_irq_o);

  a_r9_overrun_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rb_full && !rd_data) |=> err_q[0]);

  a_r10_sticky_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((err_q & $past(keep)) == $past(keep)));

  a_r10_set_only_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(err_q & ~$past(err_q))) |-> $past(rx_done));
endmodule

bind uart_cts_port uart_cts_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .clr_bits(wdata_i[2:0]), .cts_s(cts_s),
  .tx_busy(tx_busy), .tx_load(tx_load), .tb_full(tb_full),
  .rx_done(rx_done), .rb_full(rb_full), .err_q(err_q), .rx_irq_o(rx_irq_o)
);

// File: tb/uart_cts_port_test.sv
module uart_cts_port_test;
  localparam int DIV = 1;
  localparam int BIT = 16 * (DIV + 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd;
  logic       cts_n = 1'b1;
  logic       rx_irq, tx_irq, err_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_cts_port uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd), .cts_ni(cts_n),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq), .err_irq_o(err_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic exp_par(input logic [7:0] d, input bit len8, input bit odd);
    return (^(len8 ? d : {1'b0, d[6:0]})) ^ odd;
  endfunction

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit len8, input bit odd, input bit two,
                         input bit bad_par, input bit bad_stop);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < (len8 ? 8 : 7); i++) drive_bit(d[i]);
    drive_bit(exp_par(d, len8, odd) ^ bad_par);
    if (two) begin
      drive_bit(1'b1);
      drive_bit(!bad_stop);
    end else begin
      drive_bit(!bad_stop);
    end
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic capture_tx(input bit len8, input bit two, output logic [7:0] d,
                            output logic p, output bit frame_ok);
    d = '0;
    frame_ok = 1;
    while (txd) @(negedge clk);
    repeat (BIT / 2) @(negedge clk);
    if (txd) frame_ok = 0;
    for (int i = 0; i < (len8 ? 8 : 7); i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = txd;
    end
    repeat (BIT) @(negedge clk);
    p = txd;
    repeat (BIT) @(negedge clk);
    if (!txd) frame_ok = 0;
    if (two) begin
      repeat (BIT) @(negedge clk);
      if (!txd) frame_ok = 0;
    end
  endtask

  task automatic tx_case(input logic [7:0] d, input bit len8, input bit odd, input bit two);
    logic [7:0] got;
    logic p;
    bit ok;
    logic [7:0] e;
    e = len8 ? d : {1'b0, d[6:0]};
    reg_wr(2'd0, d);
    capture_tx(len8, two, got, p, ok);
    chk(got == e, "R2 tx data", got, e);
    chk(p == exp_par(d, len8, odd), "R2 tx parity", p, exp_par(d, len8, odd));
    chk(ok, "R2 tx start/stop", ok, 1);
    repeat (BIT) @(negedge clk);
    chk(tx_irq == 1'b1, "R4 tx buffer empty after send", tx_irq, 1);
  endtask

  task automatic rx_case(input logic [7:0] d, input bit len8, input bit odd, input bit two);
    logic [7:0] got;
    logic [7:0] e;
    e = len8 ? d : {1'b0, d[6:0]};
    send_rx(d, len8, odd, two, 0, 0);
    chk(rx_irq == 1'b1, "R6 rx irq set", rx_irq, 1);
    reg_rd(2'd0, got);
    chk(got == e, "R6 rx data", got, e);
    #1 chk(rx_irq == 1'b0, "R6 rx irq cleared by read", rx_irq, 0);
    reg_rd(2'd3, got);
    chk(got == 8'h00, "R7 R8 no error on clean frame", got, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin : main
    logic [7:0] v;
    bit hi;
    void'($urandom(32'h1d5e_77a3));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(rx_irq == 1'b0, "R1 rx irq", rx_irq, 0);
    chk(tx_irq == 1'b1, "R1 tx irq", tx_irq, 1);
    chk(err_irq == 1'b0, "R1 err irq", err_irq, 0);
    reg_rd(2'd1, v); chk(v == 8'h01, "R1 mode reset", v, 8'h01);
    reg_rd(2'd2, v); chk(v == 8'h00, "R1 divisor reset", v, 0);
    reg_rd(2'd3, v); chk(v == 8'h00, "R1 error reset", v, 0);

    reg_wr(2'd2, 8'(DIV));

    // R3 hold-off while cts high
    reg_wr(2'd0, 8'hA5);
    #1 chk(tx_irq == 1'b0, "R4 tx irq cleared by write", tx_irq, 0);
    hi = 1;
    repeat (3 * BIT) begin
      @(negedge clk);
      if (!txd) hi = 0;
    end
    chk(hi, "R3 txd held high while cts high", hi, 1);
    chk(tx_irq == 1'b0, "R3 character still buffered", tx_irq, 0);
    cts_n = 1'b0;
    begin
      logic [7:0] got;
      logic p;
      bit ok;
      capture_tx(1, 0, got, p, ok);
      chk(got == 8'hA5, "R3 R2 released data", got, 8'hA5);
      chk(p == exp_par(8'hA5, 1, 0), "R2 even parity", p, exp_par(8'hA5, 1, 0));
      chk(ok, "R2 framing", ok, 1);
    end
    repeat (BIT) @(negedge clk);

    // random mix of modes
    for (int it = 0; it < 12; it++) begin
      logic [2:0] m;
      logic [7:0] d;
      m = 3'($urandom);
      d = 8'($urandom);
      if (it == 0) m = 3'b000;
      if (it == 1) m = 3'b111;
      reg_wr(2'd1, {5'b0, m});
      tx_case(d, m[0], m[1], m[2]);
      rx_case(8'($urandom), m[0], m[1], m[2]);
    end

    // R7 parity error
    reg_wr(2'd1, 8'h01);
    send_rx(8'h3C, 1, 0, 0, 1, 0);
    reg_rd(2'd3, v); chk(v == 8'h04, "R7 parity error bit", v, 8'h04);
    chk(err_irq == 1'b1, "R10 err irq set", err_irq, 1);
    reg_rd(2'd0, v); chk(v == 8'h3C, "R7 data kept", v, 8'h3C);
    reg_wr(2'd3, 8'h04);
    reg_rd(2'd3, v); chk(v == 8'h00, "R10 write-1 clears", v, 0);
    chk(err_irq == 1'b0, "R10 err irq cleared", err_irq, 0);

    // R8 framing error on second stop bit
    reg_wr(2'd1, 8'h07);
    send_rx(8'h5A, 1, 1, 1, 0, 1);
    reg_rd(2'd3, v); chk(v == 8'h02, "R8 framing error bit", v, 8'h02);
    reg_rd(2'd0, v);
    reg_wr(2'd3, 8'h02);

    // R9 overrun, R10 sticky against other-bit clears
    reg_wr(2'd1, 8'h01);
    send_rx(8'h11, 1, 0, 0, 0, 0);
    send_rx(8'h22, 1, 0, 0, 0, 0);
    reg_rd(2'd3, v); chk(v == 8'h01, "R9 overrun bit", v, 8'h01);
    reg_wr(2'd3, 8'h06);
    reg_rd(2'd3, v); chk(v == 8'h01, "R10 zero write keeps bit", v, 8'h01);
    reg_rd(2'd0, v); chk(v == 8'h11, "R9 first character kept", v, 8'h11);
    reg_wr(2'd3, 8'h01);

    // R5 short glitch ignored
    @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    chk(rx_irq == 1'b0, "R5 glitch ignored", rx_irq, 0);
    reg_rd(2'd3, v); chk(v == 8'h00, "R5 no error from glitch", v, 0);
    rx_case(8'hC3, 1, 0, 0);

    finish_run();
  end
endmodule